// File: doc/BRIEF.md
# Single-precision to 12-bit minifloat converter

This block narrows an IEEE-754 single-precision value into a compact 12-bit floating-point word. The narrow word has a sign bit on top, a 4-bit exponent with a bias of 7, and a 7-bit fraction at the bottom. It is meant for datapaths that store or ship reduced-precision samples, where the wide value is produced upstream and only the compact code is kept.

The conversion rounds to the nearest representable value. When the input lies exactly halfway between two codes, the smaller magnitude is chosen. Normal results, denormal results and signed zeros are all produced. Finite inputs that are too large become a signed infinity. Infinities pass through unchanged, and any NaN becomes a single quiet NaN code. Three flags report whether the result was rounded, whether it overflowed and whether it was a rounded tiny value.

The result and flags are registered once, so they appear one clock after the input is applied.

Top module: `fp32_to_mf12`

## Requirements
- R1: Output bit 11 is the sign. Bits 10:7 hold the exponent with bias 7 and bits 6:0 hold the fraction. A normal result has value 2^(e-7) × 1.f, so 1.0 gives 0x380, -1.0 gives 0xB80 and 2^-6 gives 0x080.
- R2: Output and flags update on the first rising clock edge after the input changes and hold until that edge. An active-low asynchronous reset forces them all to zero.
- R3: A value that is not a tie rounds to the nearest code. A remainder above half an output step rounds the magnitude up, and a remainder below half truncates it. In both cases flag_inexact is set.
- R4: A value exactly halfway between two codes takes the smaller magnitude.
- R5: When rounding up a fraction of all ones, the carry moves into the exponent. For example, 0x3FFF8001 gives 0x400.
- R6: Magnitudes below 2^-6 are encoded with exponent field 0 and value fraction × 2^-13. 2^-13 gives 0x001 and 2^-7 gives 0x040.
- R7: Rounding up from the largest denormal, 127 × 2^-13, gives the smallest normal code 0x080.
- R8: The following inputs give a zero that keeps the input sign, with flag_inexact and flag_underflow set: magnitudes of 2^-14 or less, and single-precision denormal inputs.
- R9: A finite magnitude above 255.5 gives infinity (exponent 0xF, fraction 0) with the input sign, and sets flag_overflow and flag_inexact. Exactly 255.5 gives 255 (0x77F).
- R10: An infinite input gives a signed infinity with no flags. Any NaN input gives {sign, 0xF, 0x40} with no flags.
- R11: A zero input gives a zero of the same sign with no flags set.
- R12: flag_inexact is set exactly when the result differs in value from the input. flag_underflow is set exactly when flag_inexact is set and the input magnitude is below 2^-6. flag_overflow is set only when a finite input becomes infinity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fp32_in | input | 32 | Single-precision input value |
| mf_out | output | 12 | Registered 12-bit minifloat result |
| flag_inexact | output | 1 | Result was rounded |
| flag_overflow | output | 1 | Finite input became infinity |
| flag_underflow | output | 1 | Tiny input was rounded |

## Verification
Every result and flag is due exactly one rising edge after its input is applied. The bench drives each input on a falling edge and samples on the next falling edge, which is half a period after the register has updated. A directed test applies a new input and samples before the next rising edge, to confirm that the old result still holds. A second directed test asserts reset between edges and samples at once, to confirm that the reset is asynchronous.

// File: rtl/fp32_to_mf12.sv
module fp32_to_mf12 (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [31:0] fp32_in,
  output logic [11:0] mf_out,
  output logic        flag_inexact,
  output logic        flag_overflow,
  output logic        flag_underflow
);

  logic              sgn;
  logic [7:0]        ex;
  logic [22:0]       mt;
  logic signed [9:0] ue;

  assign sgn = fp32_in[31];
  assign ex  = fp32_in[30:23];
  assign mt  = fp32_in[22:0];
  assign ue  = $signed({2'b00, ex}) - 10'sd127;

  // normal path: keep 7 fraction bits, 16 bits of remainder
  logic [3:0]  n_exp;
  logic        n_up;
  logic [10:0] n_sum;

  assign n_exp = ue[3:0] + 4'd7;
  assign n_up  = mt[15:0] > 16'h8000;
  assign n_sum = {n_exp, mt[22:16]} + {10'd0, n_up};

  // denormal path: shift of 1..8 beyond the 16-bit base alignment
  logic [3:0]  d_k;
  logic [31:0] d_v;
  logic        d_up;
  logic [10:0] d_sum;

  assign d_k   = 4'd10 - ue[3:0];
  assign d_v   = {1'b1, mt, 8'd0} >> d_k;
  assign d_up  = d_v[23:0] > 24'h800000;
  assign d_sum = {3'd0, d_v[31:24]} + {10'd0, d_up};

  logic [11:0] res;
  logic        inx, ovf, unf;

  always_comb begin
    res = {sgn, 11'd0};
    inx = 1'b0;
    ovf = 1'b0;
    unf = 1'b0;
    if (ex == 8'hFF) begin
      res[10:0] = (mt != 23'd0) ? 11'h7C0 : 11'h780;
    end else if (ex == 8'h00) begin
      inx = mt != 23'd0;
      unf = inx;
    end else if (ue > 10'sd7) begin
      res[10:0] = 11'h780;
      inx = 1'b1;
      ovf = 1'b1;
    end else if (ue >= -10'sd6) begin
      res[10:0] = n_sum;
      inx = mt[15:0] != 16'd0;
      ovf = n_sum[10:7] == 4'hF;
    end else if (ue >= -10'sd14) begin
      res[10:0] = d_sum;
      inx = d_v[23:0] != 24'd0;
      unf = inx;
    end else begin
      inx = 1'b1;
      unf = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mf_out         <= 12'd0;
      flag_inexact   <= 1'b0;
      flag_overflow  <= 1'b0;
      flag_underflow <= 1'b0;
    end else begin
      mf_out         <= res;
      flag_inexact   <= inx;
      flag_overflow  <= ovf;
      flag_underflow <= unf;
    end
  end

  p_sign_keep_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !$isunknown(fp32_in) |=> mf_out[11] == $past(fp32_in[31]));

  p_nan_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (fp32_in[30:23] == 8'hFF && fp32_in[22:0] != 23'd0)
      |=> (mf_out[10:7] == 4'hF && mf_out[6] && !flag_inexact && !flag_overflow));

  p_zero_exact_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (fp32_in[30:0] == 31'd0)
      |=> (mf_out[10:0] == 11'd0 && !flag_inexact && !flag_underflow && !flag_overflow));

  p_big_ovf_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (fp32_in[30:23] > 8'd134 && fp32_in[30:23] != 8'hFF) |=> flag_overflow);

  p_no_overflow_r12: assert property (@(posedge clk) disable iff (!rst_n)
    flag_overflow |-> (mf_out[10:0] == 11'h780 && flag_inexact));

  p_uf_tiny_r12: assert property (@(posedge clk) disable iff (!rst_n)
    flag_underflow |-> (flag_inexact && mf_out[10:7] <= 4'd1 && !flag_overflow));

endmodule

// File: tb/fp32_to_mf12_bench.sv
module fp32_to_mf12_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] fp32_in = 32'h3F800000;
  logic [11:0] mf_out;
  logic        flag_inexact, flag_overflow, flag_underflow;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  fp32_to_mf12 u_fp32_to_mf12 (
    .clk(clk), .rst_n(rst_n), .fp32_in(fp32_in), .mf_out(mf_out),
    .flag_inexact(flag_inexact), .flag_overflow(flag_overflow),
    .flag_underflow(flag_underflow)
  );

  // {req[3:0], input[31:0], result[11:0], flags {inexact, overflow, underflow}}
  localparam int NV = 34;
  localparam logic [50:0] VEC [NV] = '{
    {4'd1,  32'h3F800000, 12'h380, 3'b000},  // R1 1.0
    {4'd1,  32'hBF800000, 12'hB80, 3'b000},  // R1 -1.0
    {4'd1,  32'h3FC00000, 12'h3C0, 3'b000},  // R1 1.5
    {4'd1,  32'h42C80000, 12'h6C8, 3'b000},  // R1 100
    {4'd1,  32'h437F0000, 12'h77F, 3'b000},  // R1 255 largest finite
    {4'd1,  32'h3C800000, 12'h080, 3'b000},  // R1 2^-6 smallest normal
    {4'd3,  32'h3F808001, 12'h381, 3'b100},  // R3 above half
    {4'd3,  32'h3F807FFF, 12'h380, 3'b100},  // R3 below half
    {4'd3,  32'h40490FDB, 12'h449, 3'b100},  // R3 pi
    {4'd3,  32'hBDCCCCCD, 12'h9CD, 3'b100},  // R3 -0.1
    {4'd4,  32'h3F808000, 12'h380, 3'b100},  // R4 normal tie
    {4'd4,  32'h437F8000, 12'h77F, 3'b100},  // R4 255.5 tie
    {4'd4,  32'h3C7F0000, 12'h07F, 3'b101},  // R4 denormal tie
    {4'd4,  32'h38800000, 12'h000, 3'b101},  // R4 2^-14 tie to zero
    {4'd5,  32'h3FFF8001, 12'h400, 3'b100},  // R5 carry to exponent
    {4'd6,  32'h39000000, 12'h001, 3'b000},  // R6 2^-13
    {4'd6,  32'h3C000000, 12'h040, 3'b000},  // R6 2^-7
    {4'd6,  32'h38800001, 12'h001, 3'b101},  // R6 just above 2^-14
    {4'd7,  32'h3C7F0001, 12'h080, 3'b101},  // R7 denormal to normal
    {4'd8,  32'h38000000, 12'h000, 3'b101},  // R8 2^-15
    {4'd8,  32'hB8800000, 12'h800, 3'b101},  // R8 negative tiny
    {4'd8,  32'h00000001, 12'h000, 3'b101},  // R8 input denormal
    {4'd8,  32'h80000001, 12'h800, 3'b101},  // R8 negative input denormal
    {4'd9,  32'h437F8001, 12'h780, 3'b110},  // R9 above 255.5
    {4'd9,  32'h43800000, 12'h780, 3'b110},  // R9 256
    {4'd9,  32'hC3800000, 12'hF80, 3'b110},  // R9 -256
    {4'd9,  32'h7F7FFFFF, 12'h780, 3'b110},  // R9 largest single
    {4'd10, 32'h7F800000, 12'h780, 3'b000},  // R10 +inf
    {4'd10, 32'hFF800000, 12'hF80, 3'b000},  // R10 -inf
    {4'd10, 32'h7FC00000, 12'h7C0, 3'b000},  // R10 quiet NaN
    {4'd10, 32'h7F800001, 12'h7C0, 3'b000},  // R10 signalling NaN
    {4'd10, 32'hFF800001, 12'hFC0, 3'b000},  // R10 negative NaN
    {4'd11, 32'h00000000, 12'h000, 3'b000},  // R11 +0
    {4'd11, 32'h80000000, 12'h800, 3'b000}   // R11 -0
  };

  task automatic chk(input int req, input logic [14:0] got, input logic [14:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL R%0d: got out=%h flags=%b, expected out=%h flags=%b",
               req, got[14:3], got[2:0], exp[14:3], exp[2:0]);
    end
  endtask

  function automatic logic [14:0] obs();
    return {mf_out, flag_inexact, flag_overflow, flag_underflow};
  endfunction

  initial begin
    #1;
    chk(2, obs(), 15'd0);                       // R2 reset state
    @(negedge clk);
    chk(2, obs(), 15'd0);                       // R2 reset holds across an edge
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      fp32_in = VEC[i][46:15];
      @(negedge clk);
      chk(int'(VEC[i][50:47]), obs(), VEC[i][14:0]);
    end

    // R2 result holds until the next rising edge
    @(negedge clk);
    fp32_in = 32'h3FC00000;
    @(negedge clk);
    fp32_in = 32'hBF800000;
    #1;
    chk(2, obs(), {12'h3C0, 3'b000});
    @(negedge clk);
    chk(2, obs(), {12'hB80, 3'b000});

    // R12 flags from an overflowing input clear on an exact one
    fp32_in = 32'hC3800000;
    @(negedge clk);
    chk(12, obs(), {12'hF80, 3'b110});
    fp32_in = 32'h3F800000;
    @(negedge clk);
    chk(12, obs(), {12'h380, 3'b000});

    // R2 asynchronous reset between edges
    fp32_in = 32'h3C7F0000;
    @(negedge clk);
    chk(2, obs(), {12'h07F, 3'b101});
    #1 rst_n = 1'b0;
    #1;
    chk(2, obs(), 15'd0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(2, obs(), {12'h07F, 3'b101});

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule